// File: doc/BRIEF.md
# Noise-Shaped Phase-Truncation Sine Synthesizer

This block is the digital core of a direct digital frequency synthesizer. A 16-bit phase register adds a frequency word on every enabled clock. The upper 12 bits of that phase are reduced to an 8-bit table address. The reduction is done by a single-loop, fourth-order error-feedback modulator, not by dropping bits. The truncation error is therefore pushed toward high frequencies instead of forming periodic spurs. Because of this, a 256-entry sine table gives the quality that a 4096-entry table would give without shaping. The table returns a signed 12-bit amplitude each cycle.

Samples leave through a valid/ready stream port. A sample is transferred on a rising edge where `samp_valid` and `samp_ready` are both high. While `samp_valid` is high and `samp_ready` is low, the whole pipeline is frozen: the output holds, the phase does not advance and `en` has no effect. With `samp_ready` held high the block delivers one sample per clock. The output frequency is `freq_word / 65536` times the clock rate.

Top module: `nsdds_core`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the phase register, the four stored modulator errors, the output sample and `samp_valid`. After reset the first sample produced is 0.
- R2: Each advancing clock with `en` high adds `freq_word` to the phase register modulo 2^16. Sample n of a run is taken from the phase P0 + n·freq_word, where P0 is the phase when the run starts.
- R3: Let x be phase bits [15:4] (unsigned) and e1..e4 the four most recent stored errors, each 0..15 (e1 newest). Form y = x + 4·e1 − 6·e2 + 4·e3 − e4 in signed arithmetic. The table address is floor(y/16) mod 256, and the new stored error is y mod 16.
- R4: The sample for address a is round(2047·sin(2π·a/256)) in two's complement, so it always lies within ±2047.
- R5: When `en` is high on an advancing edge, `samp_valid` rises on the following advancing edge. When `en` is low on an advancing edge, `samp_valid` is low after the following advancing edge.
- R6: While `samp_valid` is high and `samp_ready` is low, `samp_valid` and `samp_data` hold, and the phase does not advance whatever `en` is. No sample is lost or repeated.
- R7: With `en` and `samp_ready` held high, a new valid sample appears on every clock once the pipeline has filled.
- R8: With a frozen phase, the long-run mean of the shaped address equals x/16, fraction included. With x = 2056 (address 128.5), the mean output over 1024 samples is within 3 of −2047·sin(π/256) ≈ −25.1. Plain truncation would give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the phase and emit a sample on this cycle |
| freq_word | input | 16 | Phase increment per enabled cycle |
| samp_valid | output | 1 | Output sample present |
| samp_ready | input | 1 | Downstream accepts the sample this cycle |
| samp_data | output | 12 | Signed sine amplitude |

## Verification
The path has two register stages. The modulator register captures the phase on an enabled edge, and the table register fills on the next advancing edge. A sample therefore appears at the ports two advancing edges after its enable, and `samp_valid` follows `en` with the same two-edge delay. The bench drives inputs and samples outputs on the falling edge. It sets `samp_ready` for the coming rising edge first, and then treats the present sample as accepted if valid and ready are both high. Each accepted sample steps an independent model of R2 to R4, so the comparison does not depend on the fill or stall timing. Stall holding is checked one falling edge after each stalled rising edge.

// File: rtl/nsdds_pkg.sv
package nsdds_pkg;

  // Quarter-wave reduced sine, rounded to nearest, scaled to 'peak'.
  function automatic int nsdds_sine_code(int idx, int abits, int peak);
    int  n;
    int  qn;
    int  q;
    int  r;
    int  k;
    int  m;
    real th;
    real term;
    real s;
    n    = 1 << abits;
    qn   = n / 4;
    q    = (idx % n) / qn;
    r    = idx % qn;
    k    = ((q % 2) == 0) ? r : (qn - r);
    th   = 2.0 * 3.141592653589793 * k / n;
    term = th;
    s    = th;
    for (int j = 1; j < 14; j++) begin
      term = -term * th * th / ((2.0 * j) * (2.0 * j + 1.0));
      s    = s + term;
    end
    m = $rtoi(peak * s + 0.5);
    return (q >= 2) ? -m : m;
  endfunction

endpackage

// File: rtl/nsdds_phase_acc.sv
module nsdds_phase_acc #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [ACC_W-1:0] incr,
  output logic [ACC_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (rst)       phase <= '0;
    else if (step) phase <= phase + incr;
  end
endmodule

// File: rtl/nsdds_ns_mod.sv
module nsdds_ns_mod #(
  parameter int PH_W   = 12,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [PH_W-1:0]   phase_in,
  output logic [ADDR_W-1:0] addr
);
  localparam int DROP  = PH_W - ADDR_W;
  localparam int SW    = PH_W + DROP + 2;
  localparam int ORDER = 4;

  logic [DROP-1:0]        err [ORDER];
  logic signed [SW-1:0]   ex  [ORDER];
  logic signed [SW-1:0]   fb;
  logic signed [SW-1:0]   y;

  for (genvar k = 0; k < ORDER; k++) begin : g_ext
    assign ex[k] = signed'(SW'(err[k]));
  end

  // error filter 4, -6, 4, -1 on newest..oldest
  always_comb begin
    fb = (ex[0] <<< 2) - (ex[1] <<< 2) - (ex[1] <<< 1) + (ex[2] <<< 2) - ex[3];
    y  = signed'(SW'(phase_in)) + fb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      for (int k = 0; k < ORDER; k++) err[k] <= '0;
    end else if (step) begin
      addr   <= y[DROP +: ADDR_W];
      err[0] <= y[DROP-1:0];
      for (int k = 1; k < ORDER; k++) err[k] <= err[k-1];
    end
  end
endmodule

// File: rtl/nsdds_sine_rom.sv
module nsdds_sine_rom #(
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [ADDR_W-1:0]       addr,
  output logic signed [AMP_W-1:0] amp
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PEAK  = (1 << (AMP_W - 1)) - 1;

  typedef logic signed [AMP_W-1:0] tbl_t [DEPTH];

  function automatic tbl_t build_tbl();
    tbl_t t;
    for (int i = 0; i < DEPTH; i++)
      t[i] = AMP_W'(nsdds_pkg::nsdds_sine_code(i, ADDR_W, PEAK));
    return t;
  endfunction

  localparam tbl_t TBL = build_tbl();

  always_ff @(posedge clk) begin
    if (rst)       amp <= '0;
    else if (load) amp <= TBL[addr];
  end
endmodule

// File: rtl/nsdds_core.sv
module nsdds_core #(
  parameter int ACC_W  = 16,
  parameter int PH_W   = 12,
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ACC_W-1:0]        freq_word,
  output logic                    samp_valid,
  input  logic                    samp_ready,
  output logic signed [AMP_W-1:0] samp_data
);
  logic              adv;
  logic              step;
  logic              mod_vld;
  logic [ACC_W-1:0]  acc_q;
  logic [ADDR_W-1:0] addr_q;

  assign adv  = !samp_valid || samp_ready;
  assign step = adv && en;

  nsdds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .step(step), .incr(freq_word), .phase(acc_q)
  );

  nsdds_ns_mod #(.PH_W(PH_W), .ADDR_W(ADDR_W)) u_ns (
    .clk(clk), .rst(rst), .step(step),
    .phase_in(acc_q[ACC_W-1 -: PH_W]), .addr(addr_q)
  );

  nsdds_sine_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
    .clk(clk), .rst(rst), .load(adv && mod_vld), .addr(addr_q), .amp(samp_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_vld    <= 1'b0;
      samp_valid <= 1'b0;
    end else if (adv) begin
      mod_vld    <= en;
      samp_valid <= mod_vld;
    end
  end
endmodule

// File: rtl/nsdds_core_chk.sv
module nsdds_core_chk #(
  parameter int ACC_W = 16,
  parameter int AMP_W = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic [ACC_W-1:0]        freq_word,
  input logic                    samp_valid,
  input logic                    samp_ready,
  input logic signed [AMP_W-1:0] samp_data,
  input logic [ACC_W-1:0]        acc_q
);
  localparam int PEAK = (1 << (AMP_W - 1)) - 1;
  logic go;
  assign go = !samp_valid || samp_ready;

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    samp_valid && !samp_ready |=> samp_valid && $stable(samp_data));

  p_phase_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    samp_valid && !samp_ready |=> $stable(acc_q));

  p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
    en && go |=> acc_q == ACC_W'($past(acc_q) + $past(freq_word)));

  p_amp_range_r4: assert property (@(posedge clk) disable iff (rst)
    samp_valid |-> (samp_data <= PEAK) && (samp_data >= -PEAK));

  p_fill_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(en && go) && go |=> samp_valid);

  p_drain_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(!en && go) && go |=> !samp_valid);
endmodule

bind nsdds_core nsdds_core_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .freq_word(freq_word),
  .samp_valid(samp_valid), .samp_ready(samp_ready),
  .samp_data(samp_data), .acc_q(acc_q)
);

// File: tb/sim_nsdds_core.sv
module sim_nsdds_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [15:0] freq_word = '0;
  logic        samp_ready = 1'b1;
  logic        samp_valid;
  logic signed [11:0] samp_data;

  int n_chk = 0;
  int n_err = 0;
  int m_acc, m_fw;
  int m_e[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  nsdds_core u0 (
    .clk(clk), .rst(rst), .en(en), .freq_word(freq_word),
    .samp_valid(samp_valid), .samp_ready(samp_ready), .samp_data(samp_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_amp(input int a);
    real v;
    v = 2047.0 * $sin(2.0 * 3.141592653589793 * a / 256.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  // R2/R3/R4 model, one step per accepted sample
  task automatic model_step(output int exp);
    int x, fb, y, a;
    x  = (m_acc >> 4) & 4095;
    fb = 4*m_e[0] - 6*m_e[1] + 4*m_e[2] - m_e[3];
    y  = x + fb;
    a  = (y >>> 4) & 255;
    m_e[3] = m_e[2]; m_e[2] = m_e[1]; m_e[1] = m_e[0]; m_e[0] = y & 15;
    m_acc = (m_acc + m_fw) & 65535;
    exp = ref_amp(a);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0; samp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_acc = 0;
    for (int k = 0; k < 4; k++) m_e[k] = 0;
  endtask

  // R1, R5: reset state, fill and drain latency, restart after reset
  task automatic t_reset();
    int e;
    do_reset();
    chk("R1 valid after reset", samp_valid, 0);
    chk("R1 data after reset", samp_data, 0);
    freq_word = 16'h0345; m_fw = 16'h0345; en = 1'b1;
    @(negedge clk);
    chk("R5 valid one edge after en", samp_valid, 0);
    @(negedge clk);
    chk("R5 valid two edges after en", samp_valid, 1);
    model_step(e);
    chk("R1 first sample zero", samp_data, e);
    en = 1'b0;
    @(negedge clk);
    chk("R5 still valid one edge after en low", samp_valid, 1);
    model_step(e);
    chk("R2 second sample", samp_data, e);
    @(negedge clk);
    chk("R5 drained two edges after en low", samp_valid, 0);
    en = 1'b1;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; en = 1'b0;
    chk("R1 valid cleared mid-run", samp_valid, 0);
    chk("R1 data cleared mid-run", samp_data, 0);
    m_acc = 0;
    for (int k = 0; k < 4; k++) m_e[k] = 0;
    en = 1'b1;
    repeat (2) @(negedge clk);
    model_step(e);
    chk("R1 restart sample", samp_data, e);
    @(negedge clk);
    model_step(e);
    chk("R1 errors cleared, second sample", samp_data, e);
    en = 1'b0;
  endtask

  // mode 0: free run; 1: ready gaps; 2: en gaps; 3: both
  task automatic t_stream(input logic [15:0] fw, input int n_out, input int mode, input string tag);
    int got = 0, cyc = 0, e = 0, bad = 0;
    logic prev_stall = 1'b0, seen = 1'b0;
    logic signed [11:0] prev_data = '0;
    do_reset();
    freq_word = fw; m_fw = fw; en = 1'b1;
    while (got < n_out && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (prev_stall) begin
        chk({tag, " R6 valid held in stall"}, samp_valid, 1);
        chk({tag, " R6 data held in stall"}, samp_data, prev_data);
      end
      samp_ready = (mode == 1 || mode == 3) ? ((cyc % 3) != 1) : 1'b1;
      en         = (mode == 2 || mode == 3) ? ((cyc % 5) < 3) : 1'b1;
      if (mode == 0 && seen && !samp_valid) bad++;
      if (samp_valid && samp_ready) begin
        model_step(e);
        chk({tag, " R2 R3 R4 sample"}, samp_data, e);
        got++;
        seen = 1'b1;
      end
      prev_stall = samp_valid && !samp_ready;
      prev_data  = samp_data;
    end
    chk({tag, " sample count"}, got, n_out);
    if (mode == 0) chk({tag, " R7 one sample per clock"}, bad, 0);
    en = 1'b0; samp_ready = 1'b1;
  endtask

  // R8: frozen phase at address 128.5, mean must follow the fraction
  task automatic t_average();
    int got = 0, e, sum = 0, cyc = 0;
    real mean, expm;
    do_reset();
    freq_word = 16'h8080; m_fw = 16'h8080; en = 1'b1; samp_ready = 1'b1;
    @(negedge clk);
    freq_word = 16'h0000;
    while (got < 1032 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (samp_valid) begin
        model_step(e);
        if (got == 0) m_fw = 0;
        if (got < 4 || got % 64 == 0) chk("R8 R3 shaped sample", samp_data, e);
        if (got >= 8) sum += samp_data;
        got++;
      end
    end
    mean = sum / 1024.0;
    expm = -2047.0 * $sin(3.141592653589793 / 256.0);
    n_chk++;
    if (mean > expm + 3.0 || mean < expm - 3.0) begin
      n_err++;
      $display("FAIL R8 mean: actual %f expected %f", mean, expm);
    end
    en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_stream(16'h1000, 64, 0, "exact step");
    t_stream(16'h0123, 300, 0, "slow");
    t_stream(16'hFFFF, 200, 0, "wrap");
    t_stream(16'h2345, 300, 1, "ready gaps");
    t_stream(16'h0777, 300, 2, "en gaps");
    t_stream(16'h7FFF, 300, 3, "mixed gaps");
    t_average();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule